// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block manages one 8-bit general-purpose port whose pins can each be claimed by an alternate bus-control function. Software reaches three byte-wide registers over a simple bus: a data latch, a direction register and a pin-assignment register. A pin whose assignment bit is clear is an ordinary I/O pin. It drives the latched value, and its output enable comes from the direction bit. A pin whose assignment bit is set passes the output value and output enable of its alternate function, which arrive on per-pin input ports, straight to the pad.

The data latch answers at two byte offsets, 0x11 and 0x13, which share one storage. The direction register sits at 0x15 and the assignment register at 0x17. Each register uses only the low byte of the 16-bit data word. When software reads the data register, a pin that is a discrete input (I/O mode, direction input) returns its live pin level. Every other pin returns the latched bit. While reset is held, the assignment register copies a strap bit (data bus bit 8) into all eight positions, so the whole port comes up either as bus control or as plain I/O. The data latch is never reset.

A small two-state machine tracks reset. STRAP is the state while reset is held, and it captures the strap. ACTIVE is the normal operating state, and the strap has no effect in it. The transition STRAP→ACTIVE happens on the first clock edge that samples reset released. The transition ACTIVE→STRAP happens on any clock edge that samples reset asserted.

Top module: `gpio_mux_port`

## Requirements
- R1: Writes to offset 0x11 and to offset 0x13 update the same data latch, and a read at either offset returns the same value.
- R2: A pin with assignment bit 0 and direction bit 1 has pin_oe = 1 and pin_out equal to its latched data bit.
- R3: A pin with assignment bit 0 and direction bit 0 has pin_oe = 0, and its bit in a data-register read is the live pin_in level.
- R4: A data-register read returns the latched bit for every pin that is a direction output or in bus-control mode.
- R5: The direction register is read and written at offset 0x15 (1 = output) and holds 0x00 after reset.
- R6: The assignment register is read and written at offset 0x17. A pin whose bit is 1 takes pin_out from alt_out and pin_oe from alt_oe.
- R7: While rst_n is low, the assignment register loads 0xFF if strap_bit is 1 and 0x00 if strap_bit is 0.
- R8: Once reset is released, toggling strap_bit does not change the assignment register.
- R9: Bits 15:8 of every read are 0, and bits 15:8 of a write are ignored. Reads of any other offset return 0, and writes to any other offset change no register.
- R10: A register write takes effect on the rising clock edge that samples bus_wr high. Reads are combinational on bus_addr.
- R11: Reset leaves the data latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_bit | input | 1 | Data bus bit 8, sampled while reset is held |
| bus_addr | input | 5 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data (low byte used) |
| bus_rdata | output | 16 | Read data for bus_addr |
| pin_in | input | 8 | Pad input levels |
| alt_out | input | 8 | Output values from the bus-control functions |
| alt_oe | input | 8 | Output enables from the bus-control functions |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
A write becomes visible after one clock edge. The bench raises bus_wr at a falling edge, lets one rising edge pass, and samples the register, the readback and the pad outputs at the next falling edge. Reads, pad outputs and the effect of pin_in or alt_* have zero cycles of latency, so the bench drives those inputs and checks a couple of nanoseconds later, without a clock edge in between. To check R10, the bench reads the old value before the write edge and the new value after it. The strap checks sample only after the clock edge that first sees reset released.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    localparam int PORT_W = 8;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_DATA_A = 5'h11;
    localparam logic [ADDR_W-1:0] OFF_DATA_B = 5'h13;
    localparam logic [ADDR_W-1:0] OFF_DIR    = 5'h15;
    localparam logic [ADDR_W-1:0] OFF_ASSIGN = 5'h17;

    typedef enum logic [0:0] {
        ST_STRAP  = 1'b0,
        ST_ACTIVE = 1'b1
    } port_state_e;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
    import gpio_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              sel_data,
    output logic              sel_dir,
    output logic              sel_asg,
    output logic              data_we,
    output logic              dir_we,
    output logic              asg_we
);

    always_comb begin
        sel_data = (addr == OFF_DATA_A) || (addr == OFF_DATA_B);
        sel_dir  = (addr == OFF_DIR);
        sel_asg  = (addr == OFF_ASSIGN);
        data_we  = wr && sel_data;
        dir_we   = wr && sel_dir;
        asg_we   = wr && sel_asg;
    end

    // R9
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_we, dir_we, asg_we}));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_mux_pkg::*;
#(
    parameter int W = PORT_W
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strap_i,
    input  logic [W-1:0] wdata,
    input  logic         data_we,
    input  logic         dir_we,
    input  logic         asg_we,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] ddr_q,
    output logic [W-1:0] pa_q
);

    port_state_e state_q, state_d;
    logic        cfg_live;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STRAP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STRAP:  state_d = ST_ACTIVE;
            ST_ACTIVE: state_d = ST_ACTIVE;
            default:   state_d = ST_STRAP;
        endcase
    end

    always_comb begin
        cfg_live = 1'b0;
        unique case (state_q)
            ST_STRAP:  cfg_live = 1'b0;
            ST_ACTIVE: cfg_live = 1'b1;
            default:   cfg_live = 1'b0;
        endcase
    end

    // data latch keeps its contents through reset
    always_ff @(posedge clk) begin
        if (data_we) latch_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ddr_q <= '0;
            pa_q  <= {W{strap_i}};
        end else begin
            if (dir_we) ddr_q <= wdata;
            if (asg_we) pa_q  <= wdata;
        end
    end

    // R7
    strap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pa_q == {W{$past(strap_i)}}));

    // R5
    dir_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ddr_q == '0));

    // R8
    strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_live && !asg_we) |=> $stable(pa_q));

    // R10
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_live && dir_we) |=> (ddr_q == $past(wdata)));

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_mux_pkg::*;
#(
    parameter int W = PORT_W
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pa,
    input  logic [W-1:0] ddr,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] alt_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] data_rd
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic discrete_in;
        assign discrete_in = !pa[i] && !ddr[i];
        assign pin_out[i]  = pa[i] ? alt_out[i] : latch[i];
        assign pin_oe[i]   = pa[i] ? alt_oe[i]  : ddr[i];
        assign data_rd[i]  = discrete_in ? pin_in[i] : latch[i];
    end

    // R2
    io_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe ^ ddr) & ~pa) == '0);

    // R6
    alt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_out ^ alt_out) | (pin_oe ^ alt_oe)) & pa) == '0);

    // R4
    latch_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_rd ^ latch) & (pa | ddr)) == '0);

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_bit,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    input  logic [PORT_W-1:0] alt_out,
    input  logic [PORT_W-1:0] alt_oe,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);

    localparam int PAD_W = BUS_W - PORT_W;

    logic              sel_data, sel_dir, sel_asg;
    logic              data_we, dir_we, asg_we;
    logic [PORT_W-1:0] latch_q, ddr_q, pa_q, data_rd;
    logic              unused_hi;

    assign unused_hi = &{1'b0, bus_wdata[BUS_W-1:PORT_W]};

    gpio_reg_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .sel_data (sel_data),
        .sel_dir  (sel_dir),
        .sel_asg  (sel_asg),
        .data_we  (data_we),
        .dir_we   (dir_we),
        .asg_we   (asg_we)
    );

    gpio_port_regs #(.W(PORT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (strap_bit),
        .wdata   (bus_wdata[PORT_W-1:0]),
        .data_we (data_we),
        .dir_we  (dir_we),
        .asg_we  (asg_we),
        .latch_q (latch_q),
        .ddr_q   (ddr_q),
        .pa_q    (pa_q)
    );

    gpio_pin_mux #(.W(PORT_W)) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .pa      (pa_q),
        .ddr     (ddr_q),
        .latch   (latch_q),
        .pin_in  (pin_in),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .data_rd (data_rd)
    );

    always_comb begin
        if (sel_data)     bus_rdata = {{PAD_W{1'b0}}, data_rd};
        else if (sel_dir) bus_rdata = {{PAD_W{1'b0}}, ddr_q};
        else if (sel_asg) bus_rdata = {{PAD_W{1'b0}}, pa_q};
        else              bus_rdata = '0;
    end

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:PORT_W] == '0);

    // R1
    alias_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_DATA_B) |-> (bus_rdata[PORT_W-1:0] == data_rd));

endmodule

// File: tb/test_gpio_mux_port.sv
module test_gpio_mux_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_bit = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  pin_in = '0, alt_out = '0, alt_oe = '0;
    logic [7:0]  pin_out, pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_mux_port i_gpio_mux_port (
        .clk(clk), .rst_n(rst_n), .strap_bit(strap_bit),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .alt_out(alt_out),
        .alt_oe(alt_oe), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    typedef struct packed {
        logic        wr;
        logic [4:0]  wa;
        logic [15:0] wd;
        logic [4:0]  ra;
        logic [7:0]  pin;
        logic [7:0]  aout;
        logic [7:0]  aoe;
        logic [15:0] erd;
        logic [7:0]  eout;
        logic [7:0]  eoe;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // R3: all pins inputs, readback follows pins
        '{1'b1, 5'h11, 16'h005A, 5'h13, 8'h0F, 8'h00, 8'h00, 16'h000F, 8'h5A, 8'h00, 8'd3},
        // R2: upper nibble outputs
        '{1'b1, 5'h15, 16'h00F0, 5'h11, 8'h0F, 8'h00, 8'h00, 16'h005F, 8'h5A, 8'hF0, 8'd2},
        // R1 R9: alias write, upper byte dropped
        '{1'b1, 5'h13, 16'hFF3C, 5'h11, 8'h00, 8'h00, 8'h00, 16'h0030, 8'h3C, 8'hF0, 8'd1},
        // R6: mixed assignment
        '{1'b1, 5'h17, 16'h00C3, 5'h17, 8'hFF, 8'hAA, 8'h81, 16'h00C3, 8'hBE, 8'hB1, 8'd6},
        // R4 R9: unmapped write, bus pins read latch
        '{1'b1, 5'h1F, 16'h00FF, 5'h11, 8'h00, 8'hAA, 8'h81, 16'h0030, 8'hBE, 8'hB1, 8'd4},
        // R5: direction readback
        '{1'b0, 5'h00, 16'h0000, 5'h15, 8'h00, 8'hAA, 8'h81, 16'h00F0, 8'hBE, 8'hB1, 8'd5},
        // R9: unmapped read
        '{1'b0, 5'h00, 16'h0000, 5'h1F, 8'h00, 8'hAA, 8'h81, 16'h0000, 8'hBE, 8'hB1, 8'd9},
        // R9: in-between offset
        '{1'b0, 5'h00, 16'h0000, 5'h12, 8'h00, 8'hAA, 8'h81, 16'h0000, 8'hBE, 8'hB1, 8'd9},
        // R6: back to plain I/O
        '{1'b1, 5'h17, 16'h0000, 5'h13, 8'h0F, 8'hAA, 8'h81, 16'h003F, 8'h3C, 8'hF0, 8'd6}
    };

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [4:0] a, logic [15:0] exp);
        bus_addr = a;
        #2;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // reset with strap low
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R5 dir after reset", 5'h15, 16'h0000);
        rd_chk("R7 assign strap low", 5'h17, 16'h0000);
        check("R3 oe after reset", {8'h00, pin_oe}, 16'h0000);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            pin_in = VECS[v].pin; alt_out = VECS[v].aout; alt_oe = VECS[v].aoe;
            if (VECS[v].wr) begin
                bus_addr = VECS[v].wa; bus_wdata = VECS[v].wd; bus_wr = 1'b1;
                @(negedge clk);
                bus_wr = 1'b0;
            end
            bus_addr = VECS[v].ra;
            #2;
            check($sformatf("R%0d vec%0d rdata", VECS[v].req, v), bus_rdata, VECS[v].erd);
            check($sformatf("R%0d vec%0d pin_out", VECS[v].req, v), {8'h00, pin_out}, {8'h00, VECS[v].eout});
            check($sformatf("R%0d vec%0d pin_oe", VECS[v].req, v), {8'h00, pin_oe}, {8'h00, VECS[v].eoe});
        end

        // R3: live pin change seen without a clock edge
        pin_in = 8'h05;
        rd_chk("R3 live pin", 5'h11, 16'h0035);

        // R10: old value before the write edge, new value after it
        @(negedge clk);
        bus_addr = 5'h15; bus_wdata = 16'h000F; bus_wr = 1'b1;
        #2;
        check("R10 before edge", bus_rdata, 16'h00F0);
        @(negedge clk);
        bus_wr = 1'b0;
        rd_chk("R10 after edge", 5'h15, 16'h000F);

        // R11: latch survives reset; R7 strap high
        wr_reg(5'h15, 16'h00FF);
        wr_reg(5'h13, 16'h00A5);
        @(negedge clk);
        rst_n = 1'b0; strap_bit = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R7 assign strap high", 5'h17, 16'h00FF);
        rd_chk("R5 dir cleared", 5'h15, 16'h0000);
        alt_oe = 8'h3C; alt_out = 8'hC3;
        #2;
        check("R6 all pins alt oe", {8'h00, pin_oe}, 16'h003C);
        check("R6 all pins alt out", {8'h00, pin_out}, 16'h00C3);

        // R8: strap toggles after release
        strap_bit = 1'b0;
        repeat (2) @(negedge clk);
        strap_bit = 1'b1;
        @(negedge clk);
        strap_bit = 1'b0;
        repeat (2) @(negedge clk);
        rd_chk("R8 assign held", 5'h17, 16'h00FF);

        wr_reg(5'h17, 16'h0000);
        wr_reg(5'h15, 16'h00FF);
        rd_chk("R11 latch kept", 5'h11, 16'h00A5);
        check("R2 drive after reset", {8'h00, pin_out}, 16'h00A5);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule